// File: doc/BRIEF.md
# Interrupt Claim/Complete Controller

This block gathers several level-sensitive interrupt sources and hands them out to a few target contexts, such as processor cores or privilege levels. Every source passes through a gateway that latches a request as pending. Once the request is handed out, the gateway locks and stays locked until the handler reports that it has finished. Each context has two bit vectors of its own. One is an enable vector. The other is a separate mask vector, which hides sources from claim arbitration. Each context also drives one interrupt line.

A handler reads its context's claim/complete register to take the best eligible source. The read clears that source's pending bit in the same clock cycle. When the handler is done, it writes the source ID back to the same register. The write is accepted only when the named source is enabled for the context being written. The controller does not compare the written ID with the ID it last handed out. A write for a disabled source is dropped without any sign, and that source's gateway then stays locked. Masking never affects whether a completion is accepted.

All configuration and the claim/complete traffic share one simple register port. Read data appears one cycle after the read strobe.

Top module: `irq_claim_ctrl`

## Requirements
- R1: A claim read returns the ID of the eligible source with the highest priority. A source is eligible when it is pending, enabled for the context and unmasked for the context. On equal priority the lower ID wins. Source ID k is input bit `src_level[k-1]`.
- R2: A claim read with no eligible source returns 0, and ID 0 never names a source.
- R3: A claim clears the source's pending bit and locks its gateway in the same cycle. While the gateway is locked the source cannot become pending again, even with its input held high. A claim by any context after that returns 0 for the source.
- R4: A completion write of ID k to context c clears the lock of source k when k is enabled in context c. This holds whichever context claimed k and whatever ID was claimed last.
- R5: A completion write naming a source that is not enabled for the written context is ignored, and that source stays locked.
- R6: A completion write of 0, or of an ID above the number of sources, changes nothing.
- R7: A masked source is left out of claim arbitration and of the context's interrupt line. A completion for a masked source is still accepted when the source is enabled.
- R8: A claim never changes any enable or mask bit. Those bits change only through writes to their own registers.
- R9: `irq[c]` is registered. One clock after the state changes, it is high exactly when some source is pending, enabled, unmasked and unlocked for context c.
- R10: Address bits [4:3] select the register kind and bits [2:0] select the index. Kind 0 is priority, indexed by source ID, in data bits [2:0]. Kind 1 is enable and kind 2 is mask, each indexed by context, with data bit k standing for source k. Kind 3 is claim/complete, indexed by context. Read data is registered one cycle after `reg_re`. After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | N_SRC | Level request per source; bit k-1 is source ID k |
| reg_addr | input | ADDR_W | Register address: kind in the top two bits, index below |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (ignored when `reg_we` is high) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_re` |
| irq | output | N_CTX | Interrupt line per context |

## Verification
The assertions assume that each cycle carries at most one register operation, so a read and a write never arrive together. They also assume that claims are issued only through the register port, which makes lock changes traceable to a claim read or a completion write. The directed stimulus drives one strobe at a time, held for exactly one clock. It leaves idle cycles after each completion so that a released gateway can latch its input again before the next claim.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;

  typedef enum logic [1:0] {
    KIND_PRIO  = 2'd0,
    KIND_EN    = 2'd1,
    KIND_MASK  = 2'd2,
    KIND_CLAIM = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic lock_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      if (claim_i) begin
        pend_o <= 1'b0;
        lock_o <= 1'b1;
      end else begin
        if (level_i && !lock_o && !pend_o) pend_o <= 1'b1;
        if (complete_i) lock_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC  = 7,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]             elig_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]              win_id_o
);

  logic              found;
  logic [PRIO_W-1:0] best_pri;

  always_comb begin
    found    = 1'b0;
    best_pri = '0;
    win_id_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_i[i] && (!found || prio_i[i] > best_pri)) begin
        found    = 1'b1;
        best_pri = prio_i[i];
        win_id_o = ID_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC  = 7,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we_i,
  input  irq_claim_pkg::reg_kind_e        kind_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [N_SRC-1:0][PRIO_W-1:0]    prio_o,
  output logic [N_CTX-1:0][N_SRC-1:0]     en_o,
  output logic [N_CTX-1:0][N_SRC-1:0]     mask_o
);
  import irq_claim_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_o <= '0;
      en_o   <= '0;
      mask_o <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (kind_i == KIND_PRIO && int'(idx_i) == i + 1)
          prio_o[i] <= wdata_i[PRIO_W-1:0];
      end
      for (int c = 0; c < N_CTX; c++) begin
        if (int'(idx_i) == c) begin
          if (kind_i == KIND_EN)   en_o[c]   <= wdata_i[N_SRC:1];
          if (kind_i == KIND_MASK) mask_o[c] <= wdata_i[N_SRC:1];
        end
      end
    end
  end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter int N_SRC  = 7,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2((N_SRC + 1 > N_CTX) ? N_SRC + 1 : N_CTX),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_level,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_CTX-1:0]  irq
);
  import irq_claim_pkg::*;

  localparam int ID_W  = $clog2(N_SRC + 1);
  localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1;

  reg_kind_e                    kind;
  logic [IDX_W-1:0]             idx;
  logic [CTX_W-1:0]             ctx_idx;
  logic                         ctx_ok;
  logic                         claim_rd;
  logic                         cmp_wr;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_w;
  logic [N_CTX-1:0][N_SRC-1:0]  en_w;
  logic [N_CTX-1:0][N_SRC-1:0]  mask_w;
  logic [N_SRC-1:0]             pend_q;
  logic [N_SRC-1:0]             lock_q;
  logic [N_SRC-1:0]             cmp_ok;
  logic [N_CTX-1:0][N_SRC-1:0]  elig;
  logic [N_CTX-1:0][ID_W-1:0]   win_id;
  logic [ID_W-1:0]              sel_win;
  logic [DATA_W-1:0]            rd_val;

  assign kind     = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
  assign idx      = reg_addr[IDX_W-1:0];
  assign ctx_idx  = CTX_W'(idx);
  assign ctx_ok   = int'(idx) < N_CTX;
  assign claim_rd = reg_re && !reg_we && kind == KIND_CLAIM && ctx_ok;
  assign cmp_wr   = reg_we && kind == KIND_CLAIM && ctx_ok;
  assign sel_win  = ctx_ok ? win_id[ctx_idx] : '0;

  irq_cfg_regs #(
    .N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_we),
    .kind_i  (kind),
    .idx_i   (idx),
    .wdata_i (reg_wdata),
    .prio_o  (prio_w),
    .en_o    (en_w),
    .mask_o  (mask_w)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign cmp_ok[g] = cmp_wr && reg_wdata == DATA_W'(g + 1) && en_w[ctx_idx][g];

    irq_gateway u_gw (
      .clk        (clk),
      .rst        (rst),
      .level_i    (src_level[g]),
      .claim_i    (claim_rd && sel_win == ID_W'(g + 1)),
      .complete_i (cmp_ok[g]),
      .pend_o     (pend_q[g]),
      .lock_o     (lock_q[g])
    );
  end

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    assign elig[c] = pend_q & en_w[c] & ~mask_w[c];

    irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
      .elig_i   (elig[c]),
      .prio_i   (prio_w),
      .win_id_o (win_id[c])
    );

    always_ff @(posedge clk) begin
      if (rst) irq[c] <= 1'b0;
      else     irq[c] <= |(elig[c] & ~lock_q);
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (kind)
      KIND_PRIO: begin
        for (int i = 0; i < N_SRC; i++)
          if (int'(idx) == i + 1) rd_val[PRIO_W-1:0] = prio_w[i];
      end
      KIND_EN:    if (ctx_ok) rd_val[N_SRC:1]  = en_w[ctx_idx];
      KIND_MASK:  if (ctx_ok) rd_val[N_SRC:1]  = mask_w[ctx_idx];
      KIND_CLAIM: if (ctx_ok) rd_val[ID_W-1:0] = sel_win;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                    reg_rdata <= '0;
    else if (reg_re && !reg_we) reg_rdata <= rd_val;
  end

endmodule

// File: rtl/irq_claim_chk.sv
module irq_claim_chk #(
  parameter int N_SRC  = 7,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2((N_SRC + 1 > N_CTX) ? N_SRC + 1 : N_CTX),
  localparam int ADDR_W = IDX_W + 2,
  localparam int CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input logic                           clk,
  input logic                           rst,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic                           reg_we,
  input logic                           reg_re,
  input logic [DATA_W-1:0]              reg_wdata,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic [N_CTX-1:0]               irq,
  input logic [N_SRC-1:0]               pend,
  input logic [N_SRC-1:0]               lock,
  input logic [N_CTX-1:0][N_SRC-1:0]    en,
  input logic [N_CTX-1:0][N_SRC-1:0]    mask,
  input logic [N_SRC-1:0][PRIO_W-1:0]   prio
);

  logic             is_claim_kind;
  logic             ctx_ok;
  logic [CTX_W-1:0] cidx;
  logic             claim_c;
  logic             cmp_c;

  assign is_claim_kind = reg_addr[ADDR_W-1 -: 2] == 2'd3;
  assign ctx_ok        = int'(reg_addr[IDX_W-1:0]) < N_CTX;
  assign cidx          = CTX_W'(reg_addr[IDX_W-1:0]);
  assign claim_c       = reg_re && !reg_we && is_claim_kind && ctx_ok;
  assign cmp_c         = reg_we && is_claim_kind && ctx_ok;

  AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_we) |-> $stable(mask) && $stable(en) && $stable(prio)); // R8

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> ($past(pend) != '0)); // R9

  for (genvar i = 0; i < N_SRC; i++) begin : g_src_chk
    AST_LOCK_BLOCKS_PEND: assert property (@(posedge clk) disable iff (rst)
      lock[i] |-> !pend[i]); // R3

    AST_CLAIM_TAKES_PENDING: assert property (@(posedge clk) disable iff (rst)
      $past(claim_c) && reg_rdata == DATA_W'(i + 1) |-> $past(pend[i]) && lock[i] && !pend[i]); // R1

    AST_DISABLED_CMP_DROPPED: assert property (@(posedge clk) disable iff (rst)
      $past(lock[i]) && $past(cmp_c) && $past(reg_wdata) == DATA_W'(i + 1)
        && !$past(en[cidx][i]) |-> lock[i]); // R5

    AST_LOCK_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      $past(lock[i]) && !$past(reg_we) |-> lock[i]); // R4
  end

endmodule

bind irq_claim_ctrl irq_claim_chk #(
  .N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .pend      (pend_q),
  .lock      (lock_q),
  .en        (en_w),
  .mask      (mask_w),
  .prio      (prio_w)
);

// File: tb/test_irq_claim_ctrl.sv
module test_irq_claim_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  src_level = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  irq_claim_ctrl i_irq_claim_ctrl (
    .clk       (clk),
    .rst       (rst),
    .src_level (src_level),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  function automatic logic [4:0] ad(input logic [1:0] kind, input int i);
    return {kind, 3'(i)};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_claim(input int ctx, input int exp, input string req);
    logic [31:0] d;
    rd(ad(2'd3, ctx), d);
    check(d == 32'(exp), req, d, 32'(exp));
  endtask

  task automatic test_reset();
    logic [31:0] d;
    check(irq == 2'b00, "R10 irq after reset", 32'(irq), 0);
    rd(ad(2'd1, 0), d);
    check(d == 0, "R10 enable after reset", d, 0);
    expect_claim(0, 0, "R2 empty claim after reset");
  endtask

  task automatic test_basic();
    logic [31:0] d;
    wr(ad(2'd0, 3), 32'd2);
    rd(ad(2'd0, 3), d);
    check(d == 32'd2, "R10 priority readback", d, 2);
    wr(ad(2'd1, 0), 32'hFE);
    rd(ad(2'd1, 0), d);
    check(d == 32'hFE, "R10 enable readback", d, 32'hFE);
    src_level[2] = 1'b1;
    idle(3);
    check(irq == 2'b01, "R9 irq raised for enabled ctx only", 32'(irq), 1);
    expect_claim(0, 3, "R1 single source claim");
    idle(2);
    check(irq == 2'b00, "R9 irq drops after claim", 32'(irq), 0);
    expect_claim(0, 0, "R3 locked source not re-pended");
    wr(ad(2'd3, 0), 32'd3);
    idle(3);
    check(irq == 2'b01, "R4 completion reopens gateway", 32'(irq), 1);
    expect_claim(0, 3, "R4 reclaim after completion");
    src_level[2] = 1'b0;
    wr(ad(2'd3, 0), 32'd3);
    idle(3);
    expect_claim(0, 0, "R2 nothing eligible");
  endtask

  task automatic test_priority();
    wr(ad(2'd0, 2), 32'd1);
    wr(ad(2'd0, 5), 32'd4);
    wr(ad(2'd0, 6), 32'd4);
    src_level = 7'b0110010;
    idle(3);
    expect_claim(0, 5, "R1 highest priority, tie to lower ID");
    expect_claim(0, 6, "R1 second of tied pair");
    expect_claim(0, 2, "R1 lowest priority last");
    expect_claim(0, 0, "R2 all claimed");
    src_level = '0;
    wr(ad(2'd3, 0), 32'd5);
    wr(ad(2'd3, 0), 32'd6);
    wr(ad(2'd3, 0), 32'd2);
    idle(3);
  endtask

  task automatic test_mask();
    logic [31:0] d;
    src_level[4] = 1'b1;
    idle(3);
    wr(ad(2'd2, 0), 32'h20);
    idle(2);
    check(irq == 2'b00, "R7 masked source leaves irq low", 32'(irq), 0);
    expect_claim(0, 0, "R7 masked source not claimable");
    wr(ad(2'd2, 0), 32'h0);
    idle(2);
    check(irq == 2'b01, "R9 irq after unmask", 32'(irq), 1);
    expect_claim(0, 5, "R7 unmasked source claimable");
    rd(ad(2'd2, 0), d);
    check(d == 0, "R8 claim leaves mask alone", d, 0);
    rd(ad(2'd1, 0), d);
    check(d == 32'hFE, "R8 claim leaves enable alone", d, 32'hFE);
    wr(ad(2'd2, 0), 32'h20);
    wr(ad(2'd3, 0), 32'd5);
    idle(3);
    expect_claim(0, 0, "R7 still hidden while masked");
    wr(ad(2'd2, 0), 32'h0);
    idle(1);
    expect_claim(0, 5, "R7 completion accepted while masked");
    src_level[4] = 1'b0;
    wr(ad(2'd3, 0), 32'd5);
    idle(3);
  endtask

  task automatic test_completion_rules();
    src_level[3] = 1'b1;
    idle(3);
    expect_claim(0, 4, "R1 claim source 4");
    wr(ad(2'd1, 0), 32'hEE);
    wr(ad(2'd3, 0), 32'd4);
    wr(ad(2'd1, 0), 32'hFE);
    idle(3);
    expect_claim(0, 0, "R5 completion for disabled source dropped");
    check(irq == 2'b00, "R5 irq stays low while locked", 32'(irq), 0);
    wr(ad(2'd3, 0), 32'd0);
    wr(ad(2'd3, 0), 32'd8);
    idle(3);
    expect_claim(0, 0, "R6 zero and out-of-range completions ignored");
    wr(ad(2'd1, 1), 32'h10);
    wr(ad(2'd3, 1), 32'd4);
    idle(3);
    check(irq == 2'b11, "R4 completion from other context accepted", 32'(irq), 3);
    expect_claim(1, 4, "R4 claim on context 1");
    expect_claim(0, 0, "R3 second context gets nothing");
    src_level[3] = 1'b0;
    wr(ad(2'd3, 0), 32'd4);
    idle(3);
    check(irq == 2'b00, "R9 all quiet at end", 32'(irq), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    test_reset();
    test_basic();
    test_priority();
    test_mask();
    test_completion_rules();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule